// File: doc/BRIEF.md
# Multi-Master I2C Transaction Controller

This block is a bus master for a two-wire open-drain serial bus. A host hands it one request at a time: a 7-bit target address, a read/write direction, a byte count and a flag that keeps the bus after the transfer. The block then produces the start condition, the address packet, the data packets and, unless told otherwise, the stop condition. It returns read bytes, pulses a strobe each time it takes a write byte, and ends every request with a one-cycle `done` and a status code.

Both lines are driven open-drain: the block only ever pulls a line low through an output enable, and reads the real line levels back through a two-flop synchronizer. Bit timing comes from a programmable half-period count of system clocks. The block waits whenever another device holds the clock low. It watches SDA for lost arbitration, and it gives up when the clock stays low longer than a programmable limit. An external monitor tells it when the bus is free. Once a transfer has ended without a stop, the block keeps ownership and can start the next request with a repeated start, whatever the monitor says.

Top module: `i2c_mm_master`

## Requirements
- R1: After each start or repeated start, the first packet carries the target address MSB first, followed by the direction bit (0 = write, 1 = read).
- R2: Every packet uses exactly nine SCL pulses: eight data bits MSB first and one acknowledge bit. A write transfer of N bytes shows 9*(N+1) pulses, plus one final SCL rise for the stop. `wr_next` pulses once for each write byte taken.
- R3: A NACK to the address packet ends the request with status 1. A NACK to a write data byte ends it with status 2. In both cases no further byte is sent and a stop is issued, even when `req_nostop` is set.
- R4: In a read, the master ACKs every received byte except the last, which it NACKs. The bytes appear on `rd_data` with an `rd_valid` pulse, in bus order.
- R5: With `req_nostop` set and a successful transfer, `done` comes with status 0 while SCL is held low and SDA is released, and no stop is issued. The next request is accepted even if `bus_idle` is low, and it begins with a repeated start.
- R6: If the master releases SDA while it is transmitting and then samples SDA low, it ends with status 3 and releases both lines in the cycle `done` is high.
- R7: While another device holds SCL low, the bit timing does not advance. A stretched transfer completes with correct data and status 0, and it takes longer by about the stretch time.
- R8: If SCL stays low for more than `cfg_timeout` clock cycles while the master waits for it to rise, the request ends with status 4 and both lines are released.
- R9: A request made while the master does not own the bus and `bus_idle` is low ends at once with status 4'd5 semantics, that is status 5, and causes no activity on either line.
- R10: SDA changes only while SCL is low, except for the start (SDA falls while SCL is high) and the stop (SDA rises while SCL is high). Each transaction shows exactly the expected number of starts and stops.
- R11: A transfer whose packets are all acknowledged ends with a single `done` pulse and status 0. After a stop, both lines are released.
- R12: After reset, both output enables are low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | DIV_W | SCL half period in clock cycles |
| cfg_timeout | input | TMO_W | Limit in cycles for SCL held low |
| bus_idle | input | 1 | Bus monitor reports the bus free |
| req_valid | input | 1 | One-cycle request strobe |
| req_addr | input | 7 | Target address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Number of data bytes |
| req_nostop | input | 1 | Keep the bus after success |
| wr_data | input | 8 | Next byte to write |
| wr_next | output | 1 | Pulse: wr_data taken |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: rd_data valid |
| done | output | 1 | Pulse: request finished |
| status | output | 3 | 0 ok, 1 addr NACK, 2 data NACK, 3 arb lost, 4 timeout, 5 busy |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The hardest case to reach from the ports is lost arbitration. It needs a second master that pulls SDA low at the exact moment this block sends a one. The bench models that rival on the shared wired-AND line. It waits for the first SCL fall after the start and holds SDA low from there, so the address bit 0 still matches and the next bit, a one, collides. The repeated-start chain is also awkward to reach. The bench ends a write with the no-stop flag, drops `bus_idle`, and then shows that the read request is still accepted and reaches the same target without an intermediate stop.

// File: rtl/i2c_mm_master.sv
`timescale 1ns/1ps
module i2c_mm_master #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic             bus_idle,
  input  logic             req_valid,
  input  logic [6:0]       req_addr,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_nostop,
  input  logic [7:0]       wr_data,
  output logic             wr_next,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic [2:0]       status,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [2:0] C_OK = 3'd0, C_ANACK = 3'd1, C_DNACK = 3'd2,
                         C_ARB = 3'd3, C_TMO = 3'd4, C_BUSY = 3'd5;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_RSW, S_RSH, S_START, S_LO, S_HIW, S_HI, S_PLO, S_PW, S_PH
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic [7:0]       sh;
  logic [3:0]       bitn;
  logic             rd_mode, in_addr, nostop, sda_q;
  logic [LEN_W-1:0] left;
  logic [1:0]       scl_m, sda_m;
  logic             fin;
  logic [2:0]       fcode;

  wire scl_s   = scl_m[1];
  wire sda_s   = sda_m[1];
  wire waiting = (st == S_HIW) || (st == S_PW) || (st == S_RSW);
  wire tx_bit  = in_addr || !rd_mode;
  wire drive0  = (bitn != 4'd8) ? (tx_bit && !sh[7]) : (!in_addr && rd_mode && left != ONE);
  wire mid     = cnt == (cfg_half >> 1);
  wire tdone   = cnt == '0;

  assign scl_oe = (st == S_LO) || (st == S_PLO) || (st == S_HOLD);
  assign sda_oe = sda_q;

  always_comb begin
    fin = 1'b0;
    fcode = C_OK;
    if (in_addr) begin
      if (sda_s) begin fin = 1'b1; fcode = C_ANACK; end
      else if (left == '0) fin = 1'b1;
    end else if (!rd_mode && sda_s) begin
      fin = 1'b1; fcode = C_DNACK;
    end else if (left == ONE) fin = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0; sh <= '0; bitn <= '0;
      rd_mode <= 1'b0; in_addr <= 1'b0; nostop <= 1'b0; sda_q <= 1'b0;
      left <= '0; scl_m <= 2'b11; sda_m <= 2'b11;
      wr_next <= 1'b0; rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; status <= C_OK;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      done <= 1'b0; rd_valid <= 1'b0; wr_next <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      tmo <= waiting ? tmo + 1'b1 : '0;
      if (waiting && tmo == cfg_timeout) begin
        st <= S_IDLE; sda_q <= 1'b0; status <= C_TMO; done <= 1'b1;
      end else begin
        case (st)
          S_IDLE: begin
            sda_q <= 1'b0;
            if (req_valid) begin
              if (bus_idle) begin
                sh <= {req_addr, req_read}; bitn <= '0; in_addr <= 1'b1;
                rd_mode <= req_read; left <= req_len; nostop <= req_nostop;
                st <= S_START; cnt <= cfg_half; sda_q <= 1'b1;
              end else begin
                status <= C_BUSY; done <= 1'b1;
              end
            end
          end
          S_HOLD: if (req_valid) begin
            sh <= {req_addr, req_read}; bitn <= '0; in_addr <= 1'b1;
            rd_mode <= req_read; left <= req_len; nostop <= req_nostop;
            st <= S_RSW;
          end
          S_RSW:   if (scl_s) begin st <= S_RSH; cnt <= cfg_half; end
          S_RSH:   if (tdone) begin st <= S_START; cnt <= cfg_half; sda_q <= 1'b1; end
          S_START: if (tdone) begin st <= S_LO; cnt <= cfg_half; end
          S_LO: begin
            if (mid) sda_q <= drive0;
            if (tdone) st <= S_HIW;
          end
          S_HIW:   if (scl_s) begin st <= S_HI; cnt <= cfg_half; end
          S_HI: if (tdone) begin
            if (bitn != 4'd8) begin
              if (tx_bit && sh[7] && !sda_s) begin
                st <= S_IDLE; sda_q <= 1'b0; status <= C_ARB; done <= 1'b1;
              end else begin
                sh <= {sh[6:0], sda_s}; bitn <= bitn + 1'b1; st <= S_LO; cnt <= cfg_half;
              end
            end else begin
              in_addr <= 1'b0;
              if (!in_addr) left <= left - 1'b1;
              if (!in_addr && rd_mode) begin rd_data <= sh; rd_valid <= 1'b1; end
              if (fin) begin
                status <= fcode;
                if (fcode == C_OK && nostop) begin st <= S_HOLD; done <= 1'b1; end
                else begin st <= S_PLO; cnt <= cfg_half; end
              end else begin
                bitn <= '0; st <= S_LO; cnt <= cfg_half;
                if (!rd_mode) begin sh <= wr_data; wr_next <= 1'b1; end
              end
            end
          end
          S_PLO: begin
            if (mid) sda_q <= 1'b1;
            if (tdone) st <= S_PW;
          end
          S_PW:    if (scl_s) begin st <= S_PH; cnt <= cfg_half; end
          S_PH:    if (tdone) begin st <= S_IDLE; sda_q <= 1'b0; done <= 1'b1; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mm_master_chk.sv
`timescale 1ns/1ps
module i2c_mm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_idle,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done,
  input logic       wr_next,
  input logic [2:0] status
);
  p_nack_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == 3'd1 || status == 3'd2) |-> !scl_oe && !sda_oe);
  p_no_feed_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_next);
  p_hold_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd0 && scl_oe |-> !sda_oe);
  p_arb_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd3 |-> !scl_oe && !sda_oe);
  p_tmo_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd4 |-> !scl_oe && !sda_oe && $past(!scl_oe));
  p_busy_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd5 |-> $past(!bus_idle));
  p_sda_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $stable(sda_oe));
endmodule

bind i2c_mm_master i2c_mm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .done(done), .wr_next(wr_next), .status(status)
);

// File: tb/i2c_mm_master_tb_top.sv
`timescale 1ns/1ps
module i2c_mm_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] cfg_half = 8'd4;
  logic [15:0] cfg_timeout = 16'd100;
  logic bus_idle = 1'b1, req_valid = 1'b0, req_read = 1'b0, req_nostop = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [7:0] wr_data, rd_data;
  logic wr_next, rd_valid, done, scl_oe, sda_oe;
  logic [2:0] status;
  logic s_scl_hold = 1'b0, s_sda_low = 1'b0, rival_low = 1'b0;
  wire scl = !(scl_oe || s_scl_hold);
  wire sda = !(sda_oe || s_sda_low || rival_low);

  i2c_mm_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_timeout(cfg_timeout),
    .bus_idle(bus_idle), .req_valid(req_valid), .req_addr(req_addr), .req_read(req_read),
    .req_len(req_len), .req_nostop(req_nostop), .wr_data(wr_data), .wr_next(wr_next),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .status(status),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] wbuf [64];
  int widx = 0, wbase = 0, ridx = 0;
  logic [7:0] rbuf [64];
  assign wr_data = wbuf[(widx - wbase) & 63];
  always @(posedge clk) begin
    if (wr_next) widx <= widx + 1;
    if (rd_valid) begin rbuf[ridx & 63] <= rd_data; ridx <= ridx + 1; end
  end

  // target model on the wired-AND lines
  localparam logic [6:0] SADDR = 7'h2A;
  bit s_on = 0, s_match = 0, s_dir = 0, s_mnack = 0, stretch_go = 0;
  int s_bit = 0, s_mode = 0, rx_cnt = 0, tx_i = 0, nack_after = 0, stretch_ns = 0;
  int starts = 0, stops = 0, rises = 0, mack_n = 0;
  logic [7:0] s_rx = '0, s_tx = '0, addr_log = '0;
  logic [7:0] rxlog [16];
  bit mack_log [16];

  always @(posedge scl) rises++;
  always @(negedge sda) if (scl === 1'b1) begin
    starts++; s_on = 1; s_bit = 0; s_mode = 0; s_sda_low = 0; s_mnack = 0;
  end
  always @(posedge sda) if (scl === 1'b1) begin stops++; s_on = 0; s_sda_low = 0; end
  always @(posedge scl) if (s_on) begin
    if (s_bit < 8) s_rx = {s_rx[6:0], sda};
    else if (s_mode == 2) begin mack_log[mack_n & 15] = sda; mack_n++; s_mnack = sda; end
    s_bit++;
  end
  always @(negedge scl) if (s_on) begin
    if (s_bit == 8) begin
      if (s_mode == 0) begin
        s_match = (s_rx[7:1] == SADDR); addr_log = s_rx; s_dir = s_rx[0]; s_sda_low = s_match;
      end else if (s_mode == 1) begin
        rxlog[rx_cnt & 15] = s_rx; rx_cnt++;
        s_sda_low = !(nack_after != 0 && rx_cnt >= nack_after);
      end else s_sda_low = 0;
      if (stretch_ns > 0) stretch_go = 1;
    end else if (s_bit == 9) begin
      s_bit = 0; s_sda_low = 0;
      if (s_mode == 0) begin
        if (!s_match) s_on = 0; else s_mode = s_dir ? 2 : 1;
      end else if (s_mode == 2 && s_mnack) s_on = 0;
      if (s_on && s_mode == 2) begin
        s_tx = 8'hC0 + 8'(tx_i); tx_i++; s_sda_low = !s_tx[7];
      end
    end else if (s_mode == 2) s_sda_low = !s_tx[7 - s_bit];
  end
  always @(posedge stretch_go) begin
    s_scl_hold = 1; #(stretch_ns); s_scl_hold = 0; stretch_go = 0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sl_clear();
    rx_cnt = 0; mack_n = 0; tx_i = 0; nack_after = 0; stretch_ns = 0;
  endtask

  int t_end = 0;
  task automatic issue(input logic [6:0] a, input bit rd, input int n, input bit ns);
    @(negedge clk);
    wbase = widx; req_addr = a; req_read = rd; req_len = 8'(n); req_nostop = ns; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask
  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) begin errors++; checks++; $display("FAIL watchdog no done"); end
    t_end = cyc;
  endtask

  int base_len = 0;

  task automatic t_write();
    int r0 = rises, s0 = starts, p0 = stops, c0;
    sl_clear(); wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    c0 = cyc; issue(7'h2A, 0, 2, 0); wait_done(); base_len = t_end - c0;
    chk("R11 status ok", status, 0);
    chk("R1 address byte write", addr_log, 8'h54);
    chk("R2 bytes received", rx_cnt, 2);
    chk("R2 byte0", rxlog[0], 8'hA5);
    chk("R2 byte1", rxlog[1], 8'h3C);
    chk("R2 scl pulses", rises - r0, 28);
    chk("R10 starts", starts - s0, 1);
    chk("R10 stops", stops - p0, 1);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_read();
    int r0 = rises, q0 = ridx;
    sl_clear(); issue(7'h2A, 1, 3, 0); wait_done(); @(negedge clk);
    chk("R11 read status", status, 0);
    chk("R1 address byte read", addr_log, 8'h55);
    chk("R4 rd count", ridx - q0, 3);
    for (int k = 0; k < 3; k++) chk("R4 rd data", rbuf[(q0 + k) & 63], 8'hC0 + k);
    chk("R4 ack first", mack_log[0], 0);
    chk("R4 ack second", mack_log[1], 0);
    chk("R4 nack last", mack_log[2], 1);
    chk("R2 read pulses", rises - r0, 37);
  endtask

  task automatic t_addr_nack();
    int r0 = rises, p0 = stops;
    sl_clear(); wbuf[0] = 8'h11; issue(7'h11, 0, 1, 1); wait_done();
    chk("R3 addr nack status", status, 1);
    chk("R3 no data sent", rx_cnt, 0);
    chk("R3 stop issued", stops - p0, 1);
    chk("R3 pulses", rises - r0, 10);
  endtask

  task automatic t_data_nack();
    int r0 = rises, w0 = widx;
    sl_clear(); nack_after = 1; wbuf[0] = 8'h77; wbuf[1] = 8'h88; wbuf[2] = 8'h99;
    issue(7'h2A, 0, 3, 0); wait_done();
    chk("R3 data nack status", status, 2);
    chk("R3 one byte seen", rx_cnt, 1);
    chk("R3 pulses", rises - r0, 19);
    chk("R2 wr_next count", widx - w0, 1);
  endtask

  task automatic t_nostop();
    int r0 = rises, s0 = starts, p0 = stops, q0 = ridx;
    sl_clear(); wbuf[0] = 8'h5A; issue(7'h2A, 0, 1, 1); wait_done();
    chk("R5 status", status, 0);
    chk("R5 scl held", scl_oe, 1);
    chk("R5 sda free", sda_oe, 0);
    repeat (20) @(negedge clk);
    chk("R5 no stop", stops - p0, 0);
    chk("R5 pulses", rises - r0, 18);
    bus_idle = 0; r0 = rises;
    issue(7'h2A, 1, 2, 0); wait_done(); @(negedge clk);
    bus_idle = 1;
    chk("R5 chained status", status, 0);
    chk("R10 repeated start", starts - s0, 2);
    chk("R10 single stop", stops - p0, 1);
    chk("R5 chained pulses", rises - r0, 29);
    chk("R5 rd0", rbuf[q0 & 63], 8'hC0);
    chk("R5 rd1", rbuf[(q0 + 1) & 63], 8'hC1);
    chk("R5 written", rxlog[0], 8'h5A);
  endtask

  task automatic t_stretch();
    int c0;
    sl_clear(); stretch_ns = 200; wbuf[0] = 8'hE1; wbuf[1] = 8'h1E;
    c0 = cyc; issue(7'h2A, 0, 2, 0); wait_done();
    stretch_ns = 0;
    chk("R7 status", status, 0);
    chk("R7 byte0", rxlog[0], 8'hE1);
    chk("R7 byte1", rxlog[1], 8'h1E);
    chk("R7 slower", (t_end - c0) > base_len + 120, 1);
  endtask

  task automatic t_timeout();
    int c0;
    sl_clear(); wbuf[0] = 8'h00; issue(7'h2A, 0, 1, 0);
    repeat (3) @(negedge scl);
    s_scl_hold = 1; c0 = cyc; wait_done();
    chk("R8 status", status, 4);
    chk("R8 released", {scl_oe, sda_oe}, 0);
    chk("R8 window", (t_end - c0) >= 100 && (t_end - c0) <= 120, 1);
    s_on = 0; s_sda_low = 0; s_scl_hold = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_arb();
    sl_clear(); wbuf[0] = 8'h00; issue(7'h2A, 0, 1, 0);
    @(negedge scl); rival_low = 1;
    wait_done();
    chk("R6 status", status, 3);
    chk("R6 released", {scl_oe, sda_oe}, 0);
    repeat (5) @(negedge clk);
    rival_low = 0; s_on = 0; s_sda_low = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_busy();
    int r0 = rises, s0 = starts;
    bus_idle = 0; issue(7'h2A, 0, 1, 0); wait_done();
    chk("R9 status", status, 5);
    repeat (20) @(negedge clk);
    chk("R9 no pulses", rises - r0, 0);
    chk("R9 no start", starts - s0, 0);
    chk("R9 lines", {scl_oe, sda_oe}, 0);
    bus_idle = 1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R12 scl_oe", scl_oe, 0);
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 done", done, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_write(); t_read(); t_addr_nack(); t_data_nack();
    t_nostop(); t_stretch(); t_timeout(); t_arb(); t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #700000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule